// File: doc/BRIEF.md
# Conditional Branch Resolver

This combinational block resolves a conditional branch in a single pass. It reads the 4-bit condition selector out of the instruction word and evaluates it against the arithmetic flags. It also forms the branch destination from the address of the instruction and a signed displacement. The result is a taken indication, the destination address, and a marker that tells the fetch logic whether the word after the opcode held the displacement.

The displacement is normally the low byte of the opcode. When that byte is zero, the instruction carries a 16-bit displacement in the following extension word instead. Either form is sign-extended to the address width and added to the opcode address plus two, which is the address just past the opcode. The destination is produced whether or not the branch is taken, so the fetch side can start on it early. The extend flag is accepted on the flag input but plays no part in any condition.

Top module: `brcc_unit`

## Requirements
- R1: The selector is `op_word[11:8]`. Code 0000 is always taken and code 0001 is never taken, whatever the flags.
- R2: Single-flag codes: 0100 taken when C=0, 0101 when C=1, 0110 when Z=0, 0111 when Z=1, 1000 when V=0, 1001 when V=1, 1010 when N=0, 1011 when N=1.
- R3: Unsigned codes: 0010 is taken when C=0 and Z=0; 0011 is taken when C=1 or Z=1.
- R4: Signed codes: 1100 is taken when N equals V; 1101 when N differs from V; 1110 when Z=0 and N equals V; 1111 when Z=1 or N differs from V.
- R5: The flag input is laid out as bit 4 X, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Bit 4 (X) has no effect on `take_branch`.
- R6: When `op_word[7:0]` is non-zero, the displacement is that byte sign-extended, and `ext_used` is 0.
- R7: When `op_word[7:0]` is zero, the displacement is `ext_word` sign-extended, and `ext_used` is 1.
- R8: `target_addr` = `pc_addr` + 2 + displacement, taken modulo 2^ADDR_W. It is produced regardless of `take_branch`.
- R9: When `op_word[7:0]` is non-zero, `ext_word` has no effect on `target_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_word | input | 16 | Branch opcode: selector in bits 11..8, short displacement in bits 7..0 |
| ext_word | input | 16 | Word following the opcode, used as a long displacement |
| pc_addr | input | ADDR_W | Address of the opcode |
| ccr_flags | input | 5 | Flags {X, N, Z, V, C} |
| take_branch | output | 1 | Selected condition holds |
| target_addr | output | ADDR_W | Branch destination |
| ext_used | output | 1 | Extension word supplied the displacement |

## Verification
The bench sweeps all sixteen selectors against all 32 flag combinations. This catches any swap within a complementary pair, any wrong flag in a compound signed or unsigned term, and any leak of the X bit. A table of vectors mixes short positive, short negative, extreme short (+127, -128), and long displacements at both 16-bit extremes. Some of these sit at addresses that wrap, which separates a wrong sign extension, a missing +2 and a wrong format choice. Directed cases then vary the extension word under a non-zero short field to show that it cannot reach the destination.

// File: rtl/brcc_pkg.sv
package brcc_pkg;

    localparam int OPC_W        = 16;
    localparam int SHORT_DISP_W = 8;
    localparam int LONG_DISP_W  = 16;
    localparam int SEL_LSB      = 8;
    localparam int SEL_W        = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_ALWAYS   = 4'b0000,
        SEL_NEVER    = 4'b0001,
        SEL_ABOVE    = 4'b0010,
        SEL_BELOW_EQ = 4'b0011,
        SEL_NO_CARRY = 4'b0100,
        SEL_CARRY    = 4'b0101,
        SEL_NONZERO  = 4'b0110,
        SEL_ZERO     = 4'b0111,
        SEL_NO_OVF   = 4'b1000,
        SEL_OVF      = 4'b1001,
        SEL_POS      = 4'b1010,
        SEL_NEG      = 4'b1011,
        SEL_SGE      = 4'b1100,
        SEL_SLT      = 4'b1101,
        SEL_SGT      = 4'b1110,
        SEL_SLE      = 4'b1111
    } branch_sel_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    // Number of selector pairs: each odd code is the complement of its even mate
    localparam int PAIR_CNT = (1 << SEL_W) / 2;

    function automatic branch_sel_e sel_of(input logic [OPC_W-1:0] op);
        return branch_sel_e'(op[SEL_LSB +: SEL_W]);
    endfunction

    function automatic logic short_is_zero(input logic [OPC_W-1:0] op);
        return (op[SHORT_DISP_W-1:0] == '0);
    endfunction

endpackage

// File: rtl/brcc_cond_eval.sv
module brcc_cond_eval
    import brcc_pkg::*;
(
    input  branch_sel_e sel,
    input  cc_flags_t   flags,
    output logic        taken
);
    localparam int PAIR_IDX_W = SEL_W - 1;

    logic [PAIR_CNT-1:0] pair_base;
    logic                sign_match;
    logic [PAIR_IDX_W-1:0] pair_idx;

    assign sign_match = ~(flags.n ^ flags.v);

    // Even-code predicate of each pair; odd code is its inverse
    always_comb begin
        pair_base    = '0;
        pair_base[0] = 1'b1;                          // always / never
        pair_base[1] = ~flags.c & ~flags.z;           // above / below-or-equal
        pair_base[2] = ~flags.c;                      // carry clear / set
        pair_base[3] = ~flags.z;                      // nonzero / zero
        pair_base[4] = ~flags.v;                      // no overflow / overflow
        pair_base[5] = ~flags.n;                      // positive / negative
        pair_base[6] = sign_match;                    // signed ge / lt
        pair_base[7] = sign_match & ~flags.z;         // signed gt / le
    end

    assign pair_idx = sel[SEL_W-1:1];
    assign taken    = pair_base[pair_idx] ^ sel[0];

endmodule

// File: rtl/brcc_disp_sel.sv
module brcc_disp_sel
    import brcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [OPC_W-1:0]       op_word,
    input  logic [LONG_DISP_W-1:0] ext_word,
    output logic [ADDR_W-1:0]      disp,
    output logic                   use_long
);
    localparam int SHORT_PAD = ADDR_W - SHORT_DISP_W;
    localparam int LONG_PAD  = ADDR_W - LONG_DISP_W;

    logic [SHORT_DISP_W-1:0] short_f;
    logic [ADDR_W-1:0]       short_x;
    logic [ADDR_W-1:0]       long_x;

    assign short_f  = op_word[SHORT_DISP_W-1:0];
    assign use_long = short_is_zero(op_word);

    generate
        if (LONG_PAD > 0) begin : g_wide
            assign short_x = {{SHORT_PAD{short_f[SHORT_DISP_W-1]}}, short_f};
            assign long_x  = {{LONG_PAD{ext_word[LONG_DISP_W-1]}}, ext_word};
        end else begin : g_narrow
            assign short_x = ADDR_W'({{(LONG_DISP_W-SHORT_DISP_W){short_f[SHORT_DISP_W-1]}}, short_f});
            assign long_x  = ADDR_W'(ext_word);
        end
    endgenerate

    assign disp = use_long ? long_x : short_x;

endmodule

// File: rtl/brcc_target_add.sv
module brcc_target_add #(
    parameter int ADDR_W  = 32,
    parameter int OP_STEP = 2
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] disp,
    output logic [ADDR_W-1:0] dest
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(OP_STEP);

    logic [ADDR_W-1:0] next_addr;

    assign next_addr = base_addr + STEP;
    assign dest      = next_addr + disp;

endmodule

// File: rtl/brcc_unit.sv
module brcc_unit
    import brcc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [15:0]       op_word,
    input  logic [15:0]       ext_word,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic [4:0]        ccr_flags,
    output logic              take_branch,
    output logic [ADDR_W-1:0] target_addr,
    output logic              ext_used
);
    branch_sel_e       sel;
    cc_flags_t         flags;
    logic [ADDR_W-1:0] disp;

    assign sel   = sel_of(op_word);
    assign flags = cc_flags_t'(ccr_flags);

    brcc_cond_eval u_cond (
        .sel   (sel),
        .flags (flags),
        .taken (take_branch)
    );

    brcc_disp_sel #(.ADDR_W(ADDR_W)) u_disp (
        .op_word  (op_word),
        .ext_word (ext_word),
        .disp     (disp),
        .use_long (ext_used)
    );

    brcc_target_add #(.ADDR_W(ADDR_W), .OP_STEP(2)) u_add (
        .base_addr (pc_addr),
        .disp      (disp),
        .dest      (target_addr)
    );

endmodule

// File: rtl/brcc_unit_chk.sv
module brcc_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic [15:0]       op_word,
    input logic [15:0]       ext_word,
    input logic [ADDR_W-1:0] pc_addr,
    input logic [4:0]        ccr_flags,
    input logic              take_branch,
    input logic [ADDR_W-1:0] target_addr,
    input logic              ext_used
);
    logic              known;
    logic [3:0]        code;
    logic [ADDR_W-1:0] exp_short;
    logic [ADDR_W-1:0] exp_long;

    assign known = !$isunknown({op_word, ext_word, pc_addr, ccr_flags,
                                take_branch, target_addr, ext_used});
    assign code  = op_word[11:8];
    assign exp_short = pc_addr + ADDR_W'(2) + ADDR_W'($signed(op_word[7:0]));
    assign exp_long  = pc_addr + ADDR_W'(2) + ADDR_W'($signed(ext_word));

    always_comb begin
        if (known) begin
            // R1
            always_taken_chk: assert (code != 4'b0000 || take_branch)
                else $error("always code not taken");
            // R1
            never_taken_chk: assert (code != 4'b0001 || !take_branch)
                else $error("never code taken");
            // R3
            below_eq_chk: assert (code != 4'b0011 || take_branch == (ccr_flags[0] | ccr_flags[2]))
                else $error("below-or-equal mismatch");
            // R4
            signed_ge_chk: assert (code != 4'b1100 || take_branch == (ccr_flags[3] == ccr_flags[1]))
                else $error("signed ge mismatch");
            // R7
            long_form_chk: assert (ext_used == (op_word[7:0] == 8'h00))
                else $error("extension usage mismatch");
            // R6
            short_dest_chk: assert (ext_used || target_addr == exp_short)
                else $error("short destination mismatch");
            // R8
            long_dest_chk: assert (!ext_used || target_addr == exp_long)
                else $error("long destination mismatch");
        end
    end

endmodule

bind brcc_unit brcc_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .op_word     (op_word),
    .ext_word    (ext_word),
    .pc_addr     (pc_addr),
    .ccr_flags   (ccr_flags),
    .take_branch (take_branch),
    .target_addr (target_addr),
    .ext_used    (ext_used)
);

// File: tb/brcc_unit_bench.sv
module brcc_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int NVEC       = 14;

    typedef struct packed {
        logic [15:0]   op;
        logic [15:0]   ext;
        logic [AW-1:0] pc;
        logic [4:0]    fl;
        logic          tk;
        logic [AW-1:0] tgt;
        logic          xu;
    } vec_t;

    // flags {X,N,Z,V,C}
    localparam vec_t VECS [NVEC] = '{
        '{16'h6010, 16'h0000, 32'h0000_1000, 5'b00000, 1'b1, 32'h0000_1012, 1'b0}, // R1 always, R6
        '{16'h61FE, 16'h0000, 32'h0000_2000, 5'b00000, 1'b0, 32'h0000_2000, 1'b0}, // R1 never, short -2
        '{16'h6200, 16'h0100, 32'h0000_3000, 5'b00000, 1'b1, 32'h0000_3102, 1'b1}, // R3 above, R7
        '{16'h6200, 16'h0100, 32'h0000_3000, 5'b00100, 1'b0, 32'h0000_3102, 1'b1}, // R3 above with Z
        '{16'h6380, 16'h0000, 32'h0000_4000, 5'b00001, 1'b1, 32'h0000_3F82, 1'b0}, // R3 below-eq, -128
        '{16'h6600, 16'h8000, 32'h0001_0000, 5'b00000, 1'b1, 32'h0000_8002, 1'b1}, // R2 nonzero, long -32768
        '{16'h677F, 16'h0000, 32'h0000_0500, 5'b00100, 1'b1, 32'h0000_0581, 1'b0}, // R2 zero, +127
        '{16'h6C00, 16'h7FFF, 32'h0000_0000, 5'b01010, 1'b1, 32'h0000_8001, 1'b1}, // R4 ge, long +32767
        '{16'h6D04, 16'h0000, 32'h0000_0100, 5'b01000, 1'b1, 32'h0000_0106, 1'b0}, // R4 lt
        '{16'h6E04, 16'h0000, 32'h0000_0100, 5'b01110, 1'b0, 32'h0000_0106, 1'b0}, // R4 gt blocked by Z
        '{16'h6F04, 16'h0000, 32'h0000_0100, 5'b00100, 1'b1, 32'h0000_0106, 1'b0}, // R4 le via Z
        '{16'h6BFF, 16'h0000, 32'hFFFF_FFFE, 5'b10000, 1'b0, 32'hFFFF_FFFF, 1'b0}, // R2 neg, X only, R5
        '{16'h6A02, 16'h0000, 32'hFFFF_FFFE, 5'b00000, 1'b1, 32'h0000_0002, 1'b0}, // R2 pos, R8 wrap
        '{16'h6901, 16'h0000, 32'h0000_0000, 5'b00010, 1'b1, 32'h0000_0003, 1'b0}  // R2 overflow
    };

    logic          clk;
    logic          rst;
    logic [15:0]   op_word;
    logic [15:0]   ext_word;
    logic [AW-1:0] pc_addr;
    logic [4:0]    ccr_flags;
    logic          take_branch;
    logic [AW-1:0] target_addr;
    logic          ext_used;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    brcc_unit #(.ADDR_W(AW)) u_brcc_unit (
        .op_word     (op_word),
        .ext_word    (ext_word),
        .pc_addr     (pc_addr),
        .ccr_flags   (ccr_flags),
        .take_branch (take_branch),
        .target_addr (target_addr),
        .ext_used    (ext_used)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected taken value, written from R1..R4 (bits X=4 N=3 Z=2 V=1 C=0)
    function automatic logic ref_taken(input logic [3:0] code, input logic [4:0] f);
        logic n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        case (code)
            4'h0: return 1'b1;
            4'h1: return 1'b0;
            4'h2: return !c && !z;
            4'h3: return c || z;
            4'h4: return !c;
            4'h5: return c;
            4'h6: return !z;
            4'h7: return z;
            4'h8: return !v;
            4'h9: return v;
            4'hA: return !n;
            4'hB: return n;
            4'hC: return (n && v) || (!n && !v);
            4'hD: return (n && !v) || (!n && v);
            4'hE: return ((n && v) || (!n && !v)) && !z;
            default: return z || (n && !v) || (!n && v);
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] code);
        if (code <= 4'h1) return "R1";
        if (code <= 4'h3) return "R3";
        if (code <= 4'hB) return "R2";
        return "R4";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] op, input logic [15:0] ext,
                         input logic [AW-1:0] pc, input logic [4:0] fl);
        @(negedge clk);
        op_word   = op;
        ext_word  = ext;
        pc_addr   = pc;
        ccr_flags = fl;
        #(CLK_PERIOD/4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ref_tgt;
        logic          tk_a, tk_b;
        rst       = 1'b1;
        op_word   = '0;
        ext_word  = '0;
        pc_addr   = '0;
        ccr_flags = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;

        // Reset-state inputs: all zero -> always code, long form, dest 2
        apply(16'h0000, 16'h0000, '0, 5'b00000);
        check("R1", "reset taken", AW'(take_branch), AW'(1'b1));
        check("R7", "reset ext_used", AW'(ext_used), AW'(1'b1));
        check("R8", "reset target", target_addr, 32'h0000_0002);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].op, VECS[i].ext, VECS[i].pc, VECS[i].fl);
            check(req_of(VECS[i].op[11:8]), $sformatf("vec %0d taken", i),
                  AW'(take_branch), AW'(VECS[i].tk));
            check("R8", $sformatf("vec %0d target", i), target_addr, VECS[i].tgt);
            check(VECS[i].xu ? "R7" : "R6", $sformatf("vec %0d ext_used", i),
                  AW'(ext_used), AW'(VECS[i].xu));
        end

        // Exhaustive selector x flags sweep
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 32; f++) begin
                apply({4'h6, 4'(code), 8'h10}, 16'h0000, 32'h0000_0800, 5'(f));
                check(req_of(4'(code)), $sformatf("code %0h flags %b", code, 5'(f)),
                      AW'(take_branch), AW'(ref_taken(4'(code), 5'(f))));
            end
        end

        // R5: toggling X alone never changes the outcome
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                apply({4'h6, 4'(code), 8'h22}, 16'h0000, 32'h0, {1'b0, 4'(f)});
                tk_a = take_branch;
                apply({4'h6, 4'(code), 8'h22}, 16'h0000, 32'h0, {1'b1, 4'(f)});
                tk_b = take_branch;
                check("R5", $sformatf("X toggle code %0h flags %b", code, 4'(f)),
                      AW'(tk_b), AW'(tk_a));
            end
        end

        // R9: extension word ignored with a non-zero short field
        for (int k = 0; k < 6; k++) begin
            logic [15:0] ext_v;
            ext_v = (k == 0) ? 16'h0000 : (k == 1) ? 16'hFFFF : (k == 2) ? 16'h8000 :
                    (k == 3) ? 16'h7FFF : (k == 4) ? 16'h1234 : 16'h00FF;
            apply(16'h6781, ext_v, 32'h0000_9000, 5'b00100);
            ref_tgt = 32'h0000_9002 - 32'd127;
            check("R9", $sformatf("ext %h target", ext_v), target_addr, ref_tgt);
            check("R6", $sformatf("ext %h ext_used", ext_v), AW'(ext_used), AW'(1'b0));
        end

        // R8: target produced even when not taken, long form
        apply(16'h6100, 16'hFFFE, 32'h0000_0010, 5'b00000);
        check("R1", "never with long form taken", AW'(take_branch), AW'(1'b0));
        check("R8", "never with long form target", target_addr, 32'h0000_0010);

        // R7: long displacement 0 lands just past the opcode
        apply(16'h6000, 16'h0000, 32'h1234_5670, 5'b11111);
        check("R7", "long zero target", target_addr, 32'h1234_5672);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule